// File: doc/BRIEF.md
# Framer Event Status Word with Clear-on-Read

This block gathers the single-cycle event strobes and alarm levels produced by a T3/E3 line framer and holds them in one 16-bit status word for a host. Each event sets its own sticky bit, and that bit stays set until the host reads the word. The events are:

- a framing-bit or alignment-word error
- an M-bit error
- excessive zeros
- a severely errored framing event
- leaving the loss-of-signal state
- leaving the loss-of-frame state

The two alarm inputs are levels. Their bits latch when the alarm ends, not when it starts.

A single-cycle read strobe captures the whole word into the read-data register. On the same edge it clears every latched bit. An event that arrives on the same edge as the strobe is not lost. The word also carries one bit that is not latched: the received E3 national bit, reloaded at each E3 frame start. A mode input selects T3 or E3 operation. In E3 mode the M-bit event is not meaningful and is suppressed.

Top module: `frm_evt_status`

## Requirements
- R1: While reset is held, and on the first edge after it, rd_data_o is zero and every latched bit is clear.
- R2: A high fbit_err_i, exz_i or sef_i on a clock edge sets bit 2, bit 4 or bit 5 respectively. The bit stays set until the word is read.
- R3: An edge with rd_stb_i high loads rd_data_o with the word as it stood before that edge. The same edge clears all latched bits.
- R4: An event on the same edge as rd_stb_i leaves its bit set after that edge, so the next read returns it. The read on that edge does not include it.
- R5: Bit 10 sets when los_i is sampled high on one edge and low on the next. A rising or steady los_i does not set it.
- R6: Bit 11 sets when lof_i is sampled high on one edge and low on the next. A rising or steady lof_i does not set it.
- R7: With mode_e3_i low (T3), mbit_err_i sets bit 3. With mode_e3_i high (E3), mbit_err_i is ignored and bit 3 is held at zero, including a bit 3 latched earlier in T3 mode.
- R8: Bit 8 is not latched. In E3 mode it loads nat_bit_i on edges where frame_start_i is high and holds its value on other edges. In T3 mode it is zero.
- R9: Bits 0, 1, 6, 7, 9 and 12 to 15 always read zero.
- R10: rd_data_o changes only on edges where rd_stb_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e3_i | input | 1 | 1 = E3 operation, 0 = T3 operation |
| fbit_err_i | input | 1 | Framing-bit / alignment-word error strobe |
| mbit_err_i | input | 1 | M-bit error strobe |
| exz_i | input | 1 | Excessive-zeros strobe |
| sef_i | input | 1 | Severely errored framing strobe |
| los_i | input | 1 | Loss-of-signal alarm level |
| lof_i | input | 1 | Loss-of-frame alarm level |
| nat_bit_i | input | 1 | Decoded E3 national bit |
| frame_start_i | input | 1 | E3 frame start strobe |
| rd_stb_i | input | 1 | Single-cycle read strobe |
| rd_data_o | output | 16 | Status word captured on the last read |

## Verification
The state of this block can only be seen through a read, so a wrong sticky bit stays hidden until the next strobe. It then shows up in rd_data_o one cycle after that strobe. A bit that fails to clear shows up on the following read. A lost coincident event shows up as a missing bit one read later. An alarm-exit detector that fires on the wrong edge shows up as a bit 10 or bit 11 that is set during the alarm instead of after it. The bench reads often, so each of these faults reaches the ports within a few cycles of its cause.

// File: rtl/frm_evt_pkg.sv
package frm_evt_pkg;
   // number of latched event bits in the word
   localparam int NUM_EVT   = 6;
   // number of level alarms whose exit is latched
   localparam int NUM_ALARM = 2;
   // position of the real-time national bit
   localparam int NAT_POS   = 8;
   // highest bit position used in the word
   localparam int TOP_POS   = 11;

   typedef enum int {
      EV_FBIT = 0,
      EV_MBIT = 1,
      EV_EXZ  = 2,
      EV_SEF  = 3,
      EV_LOSX = 4,
      EV_LOFX = 5
   } evt_idx_e;

   // bit position in the host word for each latched event
   function automatic int evt_pos(input int idx);
      case (idx)
         EV_FBIT: return 2;
         EV_MBIT: return 3;
         EV_EXZ:  return 4;
         EV_SEF:  return 5;
         EV_LOSX: return 10;
         default: return 11;
      endcase
   endfunction
endpackage

// File: rtl/frm_alarm_exit.sv
module frm_alarm_exit #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] alarm_i,
   output logic [N-1:0] exit_o
);
   if (N < 1) begin : g_bad_n
      $error("frm_alarm_exit: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   for (genvar k = 0; k < N; k++) begin : g_alarm
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[k] <= 1'b0;
         else        prev_q[k] <= alarm_i[k];
      end
      assign exit_o[k] = prev_q[k] & ~alarm_i[k];
   end
endmodule

// File: rtl/frm_sticky_bank.sv
module frm_sticky_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] en_i,
   input  logic         clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("frm_sticky_bank: N must be at least 1");
   end

   for (genvar k = 0; k < N; k++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)       q_o[k] <= 1'b0;
         else if (!en_i[k]) q_o[k] <= 1'b0;
         else if (set_i[k]) q_o[k] <= 1'b1;
         else if (clr_i)    q_o[k] <= 1'b0;
      end

      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[k] && en_i[k]) |=> q_o[k]);
      // R3
      read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !set_i[k]) |=> !q_o[k]);
   end
endmodule

// File: rtl/frm_nat_bit.sv
module frm_nat_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_e3_i,
   input  logic frame_start_i,
   input  logic nat_bit_i,
   output logic nat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)             nat_o <= 1'b0;
      else if (!mode_e3_i)    nat_o <= 1'b0;
      else if (frame_start_i) nat_o <= nat_bit_i;
   end

   // R8
   nat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e3_i && !frame_start_i) |=> $stable(nat_o));
   // R8
   nat_t3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_e3_i |=> !nat_o);
endmodule

// File: rtl/frm_evt_status.sv
module frm_evt_status
   import frm_evt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_e3_i,
   input  logic              fbit_err_i,
   input  logic              mbit_err_i,
   input  logic              exz_i,
   input  logic              sef_i,
   input  logic              los_i,
   input  logic              lof_i,
   input  logic              nat_bit_i,
   input  logic              frame_start_i,
   input  logic              rd_stb_i,
   output logic [DATA_W-1:0] rd_data_o
);
   if (DATA_W <= TOP_POS) begin : g_bad_w
      $error("frm_evt_status: DATA_W too small for the status layout");
   end

   logic [NUM_ALARM-1:0] alarm_lvl;
   logic [NUM_ALARM-1:0] alarm_exit;
   logic [NUM_EVT-1:0]   evt_set;
   logic [NUM_EVT-1:0]   evt_en;
   logic [NUM_EVT-1:0]   evt_q;
   logic                 nat_q;
   logic [DATA_W-1:0]    word;

   assign alarm_lvl = {lof_i, los_i};

   frm_alarm_exit #(.N(NUM_ALARM)) u_exit (
      .clk     (clk),
      .rst_n   (rst_n),
      .alarm_i (alarm_lvl),
      .exit_o  (alarm_exit)
   );

   always_comb begin
      evt_set          = '0;
      evt_set[EV_FBIT] = fbit_err_i;
      evt_set[EV_MBIT] = mbit_err_i;
      evt_set[EV_EXZ]  = exz_i;
      evt_set[EV_SEF]  = sef_i;
      evt_set[EV_LOSX] = alarm_exit[0];
      evt_set[EV_LOFX] = alarm_exit[1];
      evt_en           = '1;
      evt_en[EV_MBIT]  = ~mode_e3_i;
   end

   frm_sticky_bank #(.N(NUM_EVT)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_set),
      .en_i  (evt_en),
      .clr_i (rd_stb_i),
      .q_o   (evt_q)
   );

   frm_nat_bit u_nat (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_e3_i     (mode_e3_i),
      .frame_start_i (frame_start_i),
      .nat_bit_i     (nat_bit_i),
      .nat_o         (nat_q)
   );

   always_comb begin
      word = '0;
      for (int k = 0; k < NUM_EVT; k++) begin
         word[evt_pos(k)] = evt_q[k];
      end
      word[NAT_POS] = nat_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rd_data_o <= '0;
      else if (rd_stb_i) rd_data_o <= word;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (rd_data_o == '0));
   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> $stable(rd_data_o));
   // R5
   los_exit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_exit[0] |=> evt_q[EV_LOSX]);
   // R6
   lof_exit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_exit[1] |=> evt_q[EV_LOFX]);
   // R7
   mbit_e3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e3_i && $past(mode_e3_i) && rd_stb_i) |=> !rd_data_o[evt_pos(EV_MBIT)]);
endmodule

// File: tb/frm_evt_status_test.sv
module frm_evt_status_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic mode_e3 = 0, fbit = 0, mbit = 0, exz = 0, sef = 0, los = 0, lof = 0;
   logic nat = 0, fs = 0, rd = 0;
   logic [15:0] rd_data;

   frm_evt_status uut (
      .clk(clk), .rst_n(rst_n), .mode_e3_i(mode_e3), .fbit_err_i(fbit),
      .mbit_err_i(mbit), .exz_i(exz), .sef_i(sef), .los_i(los), .lof_i(lof),
      .nat_bit_i(nat), .frame_start_i(fs), .rd_stb_i(rd), .rd_data_o(rd_data)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // behavioural reference model
   int s_f, s_m, s_z, s_s, s_los, s_lof, m_nat, p_los, p_lof, m_rd;
   function automatic int m_word();
      return (s_f << 2) | (s_m << 3) | (s_z << 4) | (s_s << 5) |
             (m_nat << 8) | (s_los << 10) | (s_lof << 11);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         s_f = 0; s_m = 0; s_z = 0; s_s = 0; s_los = 0; s_lof = 0;
         m_nat = 0; p_los = 0; p_lof = 0; m_rd = 0;
      end else begin
         int ex_los, ex_lof;
         if (rd) m_rd = m_word();
         ex_los = (p_los == 1 && los == 0) ? 1 : 0;
         ex_lof = (p_lof == 1 && lof == 0) ? 1 : 0;
         s_f   = fbit ? 1 : (rd ? 0 : s_f);
         s_z   = exz  ? 1 : (rd ? 0 : s_z);
         s_s   = sef  ? 1 : (rd ? 0 : s_s);
         s_los = ex_los ? 1 : (rd ? 0 : s_los);
         s_lof = ex_lof ? 1 : (rd ? 0 : s_lof);
         s_m   = mode_e3 ? 0 : (mbit ? 1 : (rd ? 0 : s_m));
         p_los = los; p_lof = lof;
         if (!mode_e3) m_nat = 0;
         else if (fs) m_nat = nat;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // R3 R10: compare against model on every clock
   always @(negedge clk) if (rst_n && !done) check("R3 model", int'(rd_data), m_rd);

   task automatic do_read(input int exp, input string req);
      @(negedge clk) rd = 1;
      @(negedge clk) rd = 0;
      check(req, int'(rd_data), exp);
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      case (k) 0: fbit = 1; 1: mbit = 1; 2: exz = 1; default: sef = 1; endcase
      @(negedge clk);
      fbit = 0; mbit = 0; exz = 0; sef = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(rd_data), 0);
      rst_n = 1;
      @(negedge clk);
      check("R1", int'(rd_data), 0);
      do_read(0, "R1");

      pulse(0);
      repeat (3) @(negedge clk);
      do_read(16'h0004, "R2");
      do_read(0, "R3");
      pulse(2); pulse(3);
      do_read(16'h0030, "R2");

      pulse(1);
      do_read(16'h0008, "R7");
      mode_e3 = 1;
      pulse(1);
      do_read(0, "R7");
      mode_e3 = 0;
      pulse(1);
      mode_e3 = 1;
      @(negedge clk);
      do_read(0, "R7");
      mode_e3 = 0;

      @(negedge clk) los = 1;
      repeat (3) @(negedge clk);
      do_read(0, "R5");
      @(negedge clk) los = 0;
      @(negedge clk);
      do_read(16'h0400, "R5");
      @(negedge clk) lof = 1;
      repeat (2) @(negedge clk);
      do_read(0, "R6");
      @(negedge clk) lof = 0;
      @(negedge clk);
      do_read(16'h0800, "R6");

      @(negedge clk) begin rd = 1; fbit = 1; end
      @(negedge clk) begin rd = 0; fbit = 0; end
      check("R4", int'(rd_data), 0);
      do_read(16'h0004, "R4");

      @(negedge clk) begin mode_e3 = 1; nat = 1; fs = 1; end
      @(negedge clk) begin nat = 0; fs = 0; end
      do_read(16'h0100, "R8");
      repeat (3) @(negedge clk);
      do_read(16'h0100, "R8");
      @(negedge clk) begin nat = 0; fs = 1; end
      @(negedge clk) fs = 0;
      do_read(0, "R8");
      @(negedge clk) begin nat = 1; fs = 1; end
      @(negedge clk) begin fs = 0; mode_e3 = 0; end
      @(negedge clk);
      do_read(0, "R8");

      @(negedge clk) begin fbit = 1; mbit = 1; exz = 1; sef = 1; los = 1; lof = 1; end
      @(negedge clk) begin fbit = 0; mbit = 0; exz = 0; sef = 0; los = 0; lof = 0; end
      @(negedge clk);
      do_read(16'h0C3C, "R9");
      check("R9", int'(rd_data & ~16'h0D3C), 0);
      repeat (3) begin
         @(negedge clk);
         check("R10", int'(rd_data), 16'h0C3C);
      end
      do_read(0, "R3");

      finish_run();
   end
endmodule